// File: doc/BRIEF.md
# Bus Error Capture and Routing Unit

This block sits beside a host bridge and records bus errors for software. Five error detectors feed it single-cycle pulses. The first error, or the group of errors that arrive together in one cycle, is latched into a status register. The block then freezes. Any later error only raises a sticky overflow flag until software has cleared every error bit by writing ones to the status register.

Each error source can be routed to a level-sensitive standard interrupt, to a machine check, to both, or to neither. The machine check goes to one of three processors. The unit picks the processor from the master ID captured with the first error. When that ID is absent, or when it names no processor, a programmable default field picks the target instead.

The register port is a plain synchronous write strobe with an asynchronous read mux. Four registers sit on it: status, machine-check control, interrupt enable and error attribute.

Top module: `buserr_router`

## Requirements
- R1: After reset, every register reads 0x00, and `irq_o` and `mcheck_o` are low.
- R2: Error events arrive on `err_evt_i`, with bit 0 for address time-out, bit 1 for master abort signalled, bit 2 for target abort received, bit 3 for parity error and bit 4 for system error. If no status bit is set, the events of a cycle set the matching status bits (status register, address 0, bits 4:0) on the next edge. The overflow bit is not set in this case.
- R3: An event that arrives while any status bit remains set sets the overflow bit (status bit 7). The error bits are left unchanged.
- R4: Writing 1 to a status bit (bits 4:0 and bit 7) clears that bit. Writing 0 leaves it unchanged.
- R5: If a status write and an event land in the same cycle, the clear is applied first. The event is logged as a first error if no error bit survives the clear; otherwise it sets overflow.
- R6: `irq_o` is high exactly while some status bit is set whose enable bit (address 2, bits 4:0) is 1.
- R7: Machine-check control sits at address 1, with per-source enables in bits 4:0 and a default target in bits 7:6. When an enabled status bit is set and the captured ID is valid and is 0, 1 or 2, `mcheck_o[ID]` is asserted.
- R8: If the captured ID is invalid or equals 3, the default field picks the processor. A default of 3 asserts no line. At most one `mcheck_o` line is ever high.
- R9: The master ID and its valid flag are captured with the first logged error and stay frozen until all error bits are cleared. The attribute register (address 3) reads the ID in bits 1:0 and the valid flag in bit 2.
- R10: The enable registers read back what was written. Writes to the attribute register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| err_evt_i | input | 5 | Single-cycle error event pulses |
| evt_mid_i | input | 2 | Master ID of the failing transaction |
| evt_mid_vld_i | input | 1 | Master ID is known |
| irq_o | output | 1 | Standard interrupt, level |
| mcheck_o | output | 3 | Per-processor machine check, level |

## Verification
The assertions check these rules on every cycle:
- the freeze of the error bits and of the captured master ID while an error is pending;
- overflow raising on a second event;
- exact logging of a first event;
- at most one machine-check line high;
- no output high without a pending error.

Some behaviour only the directed scenarios can show:
- the write-before-event ordering in a shared cycle;
- W1C with partial masks;
- the choice between the captured ID and the default field, including a default of 3;
- register readback and the ignored attribute write.

// File: rtl/buserr_router.sv
module buserr_router #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int NUM_SRC = 5,
  parameter int MID_W   = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [NUM_SRC-1:0]           err_evt_i,
  input  logic [MID_W-1:0]             evt_mid_i,
  input  logic                         evt_mid_vld_i,
  output logic                         irq_o,
  output logic [(2**MID_W)-2:0]        mcheck_o
);
  localparam int NUM_CPU = (2**MID_W) - 1;
  localparam int OVF_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MCEN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_INTE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ATTR = ADDR_W'(3);

  logic [NUM_SRC-1:0] err_q, inten_q, mcen_q;
  logic [MID_W-1:0]   dflt_q, mid_q;
  logic               ovf_q, mid_vld_q;

  logic               stat_wr;
  logic [NUM_SRC-1:0] err_kept;
  logic               evt_any, first_evt;

  assign stat_wr   = wr_en_i && (addr_i == A_STAT);
  assign err_kept  = stat_wr ? (err_q & ~wdata_i[NUM_SRC-1:0]) : err_q;
  assign evt_any   = |err_evt_i;
  assign first_evt = evt_any && (err_kept == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= '0;
      ovf_q     <= 1'b0;
      mid_q     <= '0;
      mid_vld_q <= 1'b0;
    end else begin
      if (first_evt) begin
        err_q     <= err_evt_i;
        mid_q     <= evt_mid_i;
        mid_vld_q <= evt_mid_vld_i;
      end else begin
        err_q <= err_kept;
      end
      if (evt_any && !first_evt)
        ovf_q <= 1'b1;
      else if (stat_wr && wdata_i[OVF_BIT])
        ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inten_q <= '0;
      mcen_q  <= '0;
      dflt_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_INTE) inten_q <= wdata_i[NUM_SRC-1:0];
      if (addr_i == A_MCEN) begin
        mcen_q <= wdata_i[NUM_SRC-1:0];
        dflt_q <= wdata_i[DATA_W-1 -: MID_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT: begin
        rdata_o[NUM_SRC-1:0] = err_q;
        rdata_o[OVF_BIT]     = ovf_q;
      end
      A_MCEN: begin
        rdata_o[NUM_SRC-1:0]         = mcen_q;
        rdata_o[DATA_W-1 -: MID_W]   = dflt_q;
      end
      A_INTE: rdata_o[NUM_SRC-1:0] = inten_q;
      A_ATTR: begin
        rdata_o[MID_W-1:0] = mid_q;
        rdata_o[MID_W]     = mid_vld_q;
      end
      default: rdata_o = '0;
    endcase
  end

  logic             mc_any, use_mid;
  logic [MID_W-1:0] tgt;

  assign irq_o   = |(err_q & inten_q);
  assign mc_any  = |(err_q & mcen_q);
  assign use_mid = mid_vld_q && (mid_q != '1);
  assign tgt     = use_mid ? mid_q : dflt_q;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_mc
    localparam logic [MID_W-1:0] IDX = MID_W'(i);
    assign mcheck_o[i] = mc_any && (tgt == IDX);
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata_i[DATA_W-MID_W-1:NUM_SRC];
endmodule

// File: rtl/buserr_router_chk.sv
module buserr_router_chk #(
  parameter int ADDR_W  = 2,
  parameter int NUM_SRC = 5,
  parameter int MID_W   = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [NUM_SRC-1:0]    err_evt_i,
  input logic [NUM_SRC-1:0]    err_q,
  input logic                  ovf_q,
  input logic [MID_W-1:0]      mid_q,
  input logic                  irq_o,
  input logic [(2**MID_W)-2:0] mcheck_o
);
  logic no_clr;
  assign no_clr = !(wr_en_i && addr_i == '0);

  AST_ERR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_q && no_clr) |=> (err_q == $past(err_q))); // R3
  AST_OVF_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_q && |err_evt_i && no_clr) |=> ovf_q); // R3
  AST_FIRST_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q == '0 && |err_evt_i) |=> (err_q == $past(err_evt_i))); // R2
  AST_MID_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_q && no_clr) |=> $stable(mid_q)); // R9
  AST_IRQ_NEEDS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |err_q); // R6
  AST_MC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mcheck_o)); // R8
  AST_MC_NEEDS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |mcheck_o |-> |err_q); // R7
endmodule

bind buserr_router buserr_router_chk #(
  .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .MID_W(MID_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .err_evt_i(err_evt_i), .err_q(err_q), .ovf_q(ovf_q), .mid_q(mid_q),
  .irq_o(irq_o), .mcheck_o(mcheck_o)
);

// File: tb/buserr_router_tb_top.sv
module buserr_router_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [4:0] err_evt_i = '0;
  logic [1:0] evt_mid_i = '0;
  logic       evt_mid_vld_i = 1'b0;
  logic       irq_o;
  logic [2:0] mcheck_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  buserr_router dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .err_evt_i(err_evt_i),
    .evt_mid_i(evt_mid_i), .evt_mid_vld_i(evt_mid_vld_i),
    .irq_o(irq_o), .mcheck_o(mcheck_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [4:0] e, input logic [1:0] m, input logic v);
    @(negedge clk_i);
    err_evt_i = e; evt_mid_i = m; evt_mid_vld_i = v;
    @(negedge clk_i);
    err_evt_i = '0; evt_mid_i = '0; evt_mid_vld_i = 1'b0;
  endtask

  task automatic wr_with_evt(input logic [7:0] d, input logic [4:0] e,
                             input logic [1:0] m, input logic v);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = d;
    err_evt_i = e; evt_mid_i = m; evt_mid_vld_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
    err_evt_i = '0; evt_mid_i = '0; evt_mid_vld_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", d, 8'h00);
    end
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 mcheck", {5'd0, mcheck_o}, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] d;
    wr(2'd2, 8'h08);
    wr(2'd1, 8'h88);
    rd(2'd2, d); chk("R10 inten readback", d, 8'h08);
    rd(2'd1, d); chk("R10 mcen readback", d, 8'h88);
  endtask

  task automatic t_first_and_route();
    logic [7:0] d;
    pulse(5'h08, 2'd1, 1'b1);
    rd(2'd0, d); chk("R2 first parity", d, 8'h08);
    chk("R6 irq set", {7'd0, irq_o}, 8'h01);
    chk("R7 mcheck cpu1", {5'd0, mcheck_o}, 8'h02);
    rd(2'd3, d); chk("R9 attr captured", d, 8'h05);
  endtask

  task automatic t_overflow_and_clear();
    logic [7:0] d;
    pulse(5'h01, 2'd2, 1'b1);
    rd(2'd0, d); chk("R3 overflow", d, 8'h88);
    rd(2'd3, d); chk("R9 attr frozen", d, 8'h05);
    chk("R7 mcheck kept", {5'd0, mcheck_o}, 8'h02);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R10 attr write ignored", d, 8'h05);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R4 zero write no effect", d, 8'h88);
    wr(2'd0, 8'h08);
    rd(2'd0, d); chk("R4 clear err bit", d, 8'h80);
    chk("R6 irq drops", {7'd0, irq_o}, 8'h00);
    chk("R7 mcheck drops", {5'd0, mcheck_o}, 8'h00);
    wr(2'd0, 8'h80);
    rd(2'd0, d); chk("R4 clear overflow", d, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    pulse(5'h01, 2'd0, 1'b0);
    rd(2'd0, d); chk("R2 time-out logged", d, 8'h01);
    chk("R6 no irq when disabled", {7'd0, irq_o}, 8'h00);
    wr_with_evt(8'h01, 5'h10, 2'd3, 1'b1);
    rd(2'd0, d); chk("R5 clear then log", d, 8'h10);
    rd(2'd3, d); chk("R5 attr recaptured", d, 8'h07);
    pulse(5'h01, 2'd0, 1'b0);
    wr_with_evt(8'h00, 5'h02, 2'd0, 1'b1);
    rd(2'd0, d); chk("R5 no clear gives overflow", d, 8'h90);
  endtask

  task automatic t_default();
    logic [7:0] d;
    wr(2'd1, 8'h90);
    chk("R8 id 3 uses default cpu2", {5'd0, mcheck_o}, 8'h04);
    wr(2'd1, 8'hD0);
    chk("R8 default 3 none", {5'd0, mcheck_o}, 8'h00);
    wr(2'd0, 8'h9F);
    pulse(5'h06, 2'd0, 1'b0);
    rd(2'd0, d); chk("R2 simultaneous first", d, 8'h06);
    wr(2'd1, 8'h44);
    chk("R8 invalid id default cpu1", {5'd0, mcheck_o}, 8'h02);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_config();
    t_first_and_route();
    t_overflow_and_clear();
    t_same_cycle();
    t_default();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule